// File: doc/BRIEF.md
# Raster Line and Frame Timer with Polled Frame Flag

This block keeps the beam position for a fixed-format, progressive-scan display. A pixel counter walks across each line and a line counter walks down the frame. Both counters drive the visible-area strobe and the horizontal and vertical sync pulses. A frame may be 262 lines long (60 Hz region) or 313 lines long (50 Hz region). The first 192 lines of either frame are visible and the rest are blanking. Each frame holds a whole number of lines, so every frame starts at the same point relative to vertical sync.

A host processor paces its work by polling a status byte. The frame flag sits in bit 7 of that byte. It is raised on the first pixel of line 192, directly after the last visible line, and not when vertical sync is output. This gives the host the longest possible window before the next visible line. Reading the status byte returns its current value, and the flag is cleared from the following cycle. If a new frame event lands in the same cycle as a read, the event wins, so no frame is lost. An interrupt line follows the flag whenever the interrupt enable is high.

Both the horizontal and the vertical sequencer are four-segment state machines: ACTIVE, FRONT, SYNC, BACK. The horizontal transitions are:
- ACTIVE to FRONT after the last visible pixel.
- FRONT to SYNC at the sync start.
- SYNC to BACK after the sync length.
- BACK to ACTIVE at the last pixel of the line.

The vertical sequencer takes the same transitions on line boundaries. The flag is a two-state machine. CLEAR goes to RAISED on a frame event. RAISED goes to CLEAR on a read that does not coincide with a frame event.

Top module: `vft_frame_timer`

## Requirements
- R1: `h_count` counts 0 to H_TOTAL-1 and wraps to 0. `v_count` advances by one on each wrap of `h_count`.
- R2: With `region_50`=0 a frame is 262 lines; with `region_50`=1 it is 313 lines. Two consecutive frame-flag rises are 262*H_TOTAL or 313*H_TOTAL cycles apart.
- R3: `region_50` is sampled only when the last line of a frame ends. A change during a frame leaves that frame's length and sync position unchanged.
- R4: `active` is 1 exactly when `h_count` < H_ACTIVE and `v_count` < 192.
- R5: `hsync` is 1 for H_SYNC_LEN pixels starting at pixel H_SYNC_START. `vsync` is 1 for V_SYNC_LEN lines starting at line V_SYNC_START_60 or V_SYNC_START_50, according to the frame's sampled region.
- R6: Status bit 7 (the frame flag) rises in the cycle where `v_count`=192 and `h_count`=0. Status bits 6..0 always read 0.
- R7: In a cycle with `rd_status`=1, `status` shows the current byte (0x80 when the flag is set). From the next cycle, bit 7 reads 0.
- R8: If a frame event and `rd_status` fall in the same cycle, bit 7 is 1 in the next cycle.
- R9: `irq` equals status bit 7 AND `irq_en`.
- R10: After reset, both counters are 0, `status` is 0x00, both syncs are low and the region is 60 Hz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| region_50 | input | 1 | 1 selects the 313-line frame, 0 the 262-line frame |
| rd_status | input | 1 | Host status-read strobe, one cycle per read |
| irq_en | input | 1 | Interrupt enable |
| h_count | output | $clog2(H_TOTAL) | Pixel position within the line |
| v_count | output | $clog2(V_TOTAL_50) | Line position within the frame |
| active | output | 1 | Visible-area strobe |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| status | output | 8 | Status byte, frame flag in bit 7 |
| irq | output | 1 | Interrupt request |

## Verification
The properties assume the segment ordering that the parameters must satisfy: visible pixels, then front porch, then sync, then back porch, each segment non-empty, with the same ordering for lines. They also assume that `rd_status` and `region_50` change only between clock edges. The stimulus drives every input one nanosecond after the rising edge. It moves `region_50` only in the middle of a frame, which exercises the frame-boundary sampling. It places one read exactly on the last pixel of line 191, which forces the set-versus-clear collision.

// File: rtl/vft_pkg.sv
package vft_pkg;

    // Segment of a line or of a frame, in scan order.
    typedef enum logic [1:0] {
        SEG_ACTIVE = 2'd0,
        SEG_FRONT  = 2'd1,
        SEG_SYNC   = 2'd2,
        SEG_BACK   = 2'd3
    } seg_e;

    // Frame flag state.
    typedef enum logic {
        FLAG_CLEAR  = 1'b0,
        FLAG_RAISED = 1'b1
    } flag_e;

    localparam int STATUS_W = 8;

endpackage

// File: rtl/vft_hseq.sv
module vft_hseq
    import vft_pkg::*;
#(
    parameter int H_TOTAL      = 342,
    parameter int H_ACTIVE     = 256,
    parameter int H_SYNC_START = 282,
    parameter int H_SYNC_LEN   = 26,
    localparam int HW          = $clog2(H_TOTAL)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [HW-1:0] h_cnt,
    output logic          h_vis,
    output logic          h_sync,
    output logic          line_last
);

    localparam logic [HW-1:0] LAST_VIS   = HW'(H_ACTIVE - 1);
    localparam logic [HW-1:0] LAST_FRONT = HW'(H_SYNC_START - 1);
    localparam logic [HW-1:0] LAST_SYNC  = HW'(H_SYNC_START + H_SYNC_LEN - 1);
    localparam logic [HW-1:0] LAST_PIX   = HW'(H_TOTAL - 1);

    seg_e          seg_q, seg_d;
    logic [HW-1:0] cnt_q;
    logic          at_end;

    assign at_end = (cnt_q == LAST_PIX);

    // State and position register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg_q <= SEG_ACTIVE;
            cnt_q <= '0;
        end else begin
            seg_q <= seg_d;
            cnt_q <= at_end ? '0 : cnt_q + HW'(1);
        end
    end

    // Next segment
    always_comb begin
        seg_d = seg_q;
        unique case (seg_q)
            SEG_ACTIVE: if (cnt_q == LAST_VIS)   seg_d = SEG_FRONT;
            SEG_FRONT:  if (cnt_q == LAST_FRONT) seg_d = SEG_SYNC;
            SEG_SYNC:   if (cnt_q == LAST_SYNC)  seg_d = SEG_BACK;
            SEG_BACK:   if (at_end)              seg_d = SEG_ACTIVE;
            default:                             seg_d = SEG_ACTIVE;
        endcase
    end

    // Outputs
    always_comb begin
        h_cnt     = cnt_q;
        h_vis     = (seg_q == SEG_ACTIVE);
        h_sync    = (seg_q == SEG_SYNC);
        line_last = at_end;
    end

endmodule

// File: rtl/vft_vseq.sv
module vft_vseq
    import vft_pkg::*;
#(
    parameter int V_ACTIVE        = 192,
    parameter int V_TOTAL_60      = 262,
    parameter int V_TOTAL_50      = 313,
    parameter int V_SYNC_START_60 = 216,
    parameter int V_SYNC_START_50 = 240,
    parameter int V_SYNC_LEN      = 3,
    localparam int VW             = $clog2(V_TOTAL_50)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_adv,
    input  logic          mode_in,
    output logic [VW-1:0] v_cnt,
    output logic          v_vis,
    output logic          v_sync,
    output logic          frame_edge
);

    localparam logic [VW-1:0] LAST_VIS  = VW'(V_ACTIVE - 1);
    localparam logic [VW-1:0] END_60    = VW'(V_TOTAL_60 - 1);
    localparam logic [VW-1:0] END_50    = VW'(V_TOTAL_50 - 1);
    localparam logic [VW-1:0] SFRONT_60 = VW'(V_SYNC_START_60 - 1);
    localparam logic [VW-1:0] SFRONT_50 = VW'(V_SYNC_START_50 - 1);
    localparam logic [VW-1:0] SLAST_60  = VW'(V_SYNC_START_60 + V_SYNC_LEN - 1);
    localparam logic [VW-1:0] SLAST_50  = VW'(V_SYNC_START_50 + V_SYNC_LEN - 1);

    seg_e          seg_q, seg_d;
    logic [VW-1:0] cnt_q;
    logic          mode_q;
    logic [VW-1:0] last_line, last_front, last_sync;
    logic          wrap;

    // Frame geometry follows the region sampled at the last frame boundary
    always_comb begin
        last_line  = mode_q ? END_50    : END_60;
        last_front = mode_q ? SFRONT_50 : SFRONT_60;
        last_sync  = mode_q ? SLAST_50  : SLAST_60;
        wrap       = line_adv && (cnt_q == last_line);
    end

    // State, line and region register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg_q  <= SEG_ACTIVE;
            cnt_q  <= '0;
            mode_q <= 1'b0;
        end else begin
            seg_q <= seg_d;
            if (line_adv) begin
                cnt_q <= wrap ? '0 : cnt_q + VW'(1);
            end
            if (wrap) begin
                mode_q <= mode_in;
            end
        end
    end

    // Next segment, evaluated only on a line boundary
    always_comb begin
        seg_d = seg_q;
        if (line_adv) begin
            unique case (seg_q)
                SEG_ACTIVE: if (cnt_q == LAST_VIS)   seg_d = SEG_FRONT;
                SEG_FRONT:  if (cnt_q == last_front) seg_d = SEG_SYNC;
                SEG_SYNC:   if (cnt_q == last_sync)  seg_d = SEG_BACK;
                SEG_BACK:   if (cnt_q == last_line)  seg_d = SEG_ACTIVE;
                default:                             seg_d = SEG_ACTIVE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        v_cnt      = cnt_q;
        v_vis      = (seg_q == SEG_ACTIVE);
        v_sync     = (seg_q == SEG_SYNC);
        frame_edge = line_adv && (seg_q == SEG_ACTIVE) && (cnt_q == LAST_VIS);
    end

endmodule

// File: rtl/vft_status.sv
module vft_status
    import vft_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_evt,
    input  logic                rd,
    input  logic                irq_en,
    output logic [STATUS_W-1:0] status,
    output logic                irq
);

    flag_e st_q, st_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= FLAG_CLEAR;
        end else begin
            st_q <= st_d;
        end
    end

    // Transitions: a frame event outranks a read in the same cycle
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FLAG_CLEAR:  if (set_evt)        st_d = FLAG_RAISED;
            FLAG_RAISED: if (rd && !set_evt) st_d = FLAG_CLEAR;
            default:                         st_d = FLAG_CLEAR;
        endcase
    end

    // Outputs
    always_comb begin
        status    = '0;
        status[7] = (st_q == FLAG_RAISED);
        irq       = (st_q == FLAG_RAISED) && irq_en;
    end

endmodule

// File: rtl/vft_frame_timer.sv
module vft_frame_timer
    import vft_pkg::*;
#(
    parameter int H_TOTAL         = 342,
    parameter int H_ACTIVE        = 256,
    parameter int H_SYNC_START    = 282,
    parameter int H_SYNC_LEN      = 26,
    parameter int V_ACTIVE        = 192,
    parameter int V_TOTAL_60      = 262,
    parameter int V_TOTAL_50      = 313,
    parameter int V_SYNC_START_60 = 216,
    parameter int V_SYNC_START_50 = 240,
    parameter int V_SYNC_LEN      = 3,
    localparam int HW             = $clog2(H_TOTAL),
    localparam int VW             = $clog2(V_TOTAL_50)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                region_50,
    input  logic                rd_status,
    input  logic                irq_en,
    output logic [HW-1:0]       h_count,
    output logic [VW-1:0]       v_count,
    output logic                active,
    output logic                hsync,
    output logic                vsync,
    output logic [STATUS_W-1:0] status,
    output logic                irq
);

    logic h_vis, v_vis, line_last, frame_edge;

    vft_hseq #(
        .H_TOTAL     (H_TOTAL),
        .H_ACTIVE    (H_ACTIVE),
        .H_SYNC_START(H_SYNC_START),
        .H_SYNC_LEN  (H_SYNC_LEN)
    ) u_hseq (
        .clk      (clk),
        .rst_n    (rst_n),
        .h_cnt    (h_count),
        .h_vis    (h_vis),
        .h_sync   (hsync),
        .line_last(line_last)
    );

    vft_vseq #(
        .V_ACTIVE       (V_ACTIVE),
        .V_TOTAL_60     (V_TOTAL_60),
        .V_TOTAL_50     (V_TOTAL_50),
        .V_SYNC_START_60(V_SYNC_START_60),
        .V_SYNC_START_50(V_SYNC_START_50),
        .V_SYNC_LEN     (V_SYNC_LEN)
    ) u_vseq (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_adv  (line_last),
        .mode_in   (region_50),
        .v_cnt     (v_count),
        .v_vis     (v_vis),
        .v_sync    (vsync),
        .frame_edge(frame_edge)
    );

    vft_status u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_evt(frame_edge),
        .rd     (rd_status),
        .irq_en (irq_en),
        .status (status),
        .irq    (irq)
    );

    assign active = h_vis && v_vis;

endmodule

// File: rtl/vft_frame_timer_chk.sv
module vft_frame_timer_chk #(
    parameter int H_TOTAL  = 342,
    parameter int V_ACTIVE = 192,
    parameter int HW       = 9,
    parameter int VW       = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_status,
    input logic          irq_en,
    input logic [HW-1:0] h_count,
    input logic [VW-1:0] v_count,
    input logic          active,
    input logic          vsync,
    input logic [7:0]    status,
    input logic          irq
);

    logic at_flag_point;
    assign at_flag_point = (int'(h_count) == H_TOTAL - 1) && (int'(v_count) == V_ACTIVE - 1);

    a_r1_h_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(h_count) == H_TOTAL - 1) |=> (h_count == '0));

    a_r1_h_step: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(h_count) != H_TOTAL - 1) |=> (int'(h_count) == int'($past(h_count)) + 1));

    a_r4_active_rows: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (int'(v_count) < V_ACTIVE));

    a_r5_vsync_blank: assert property (@(posedge clk) disable iff (!rst_n)
        vsync |-> (!active && int'(v_count) >= V_ACTIVE));

    a_r6_flag_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[7]) |-> (int'(v_count) == V_ACTIVE && h_count == '0));

    a_r7_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && status[7] && !at_flag_point) |=> !status[7]);

    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        at_flag_point |=> status[7]);

    a_r9_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_en && status[7]));

endmodule

bind vft_frame_timer vft_frame_timer_chk #(
    .H_TOTAL (H_TOTAL),
    .V_ACTIVE(V_ACTIVE),
    .HW      (HW),
    .VW      (VW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_status(rd_status),
    .irq_en   (irq_en),
    .h_count  (h_count),
    .v_count  (v_count),
    .active   (active),
    .vsync    (vsync),
    .status   (status),
    .irq      (irq)
);

// File: tb/tb_vft_frame_timer.sv
`timescale 1ns/1ps
module tb_vft_frame_timer;

    localparam int HT   = 24;
    localparam int HA   = 16;
    localparam int HSS  = 18;
    localparam int HSL  = 3;
    localparam int VA   = 192;
    localparam int VT60 = 262;
    localparam int VT50 = 313;
    localparam int VS60 = 216;
    localparam int VS50 = 240;
    localparam int VSL  = 3;
    localparam int HW   = $clog2(HT);
    localparam int VW   = $clog2(VT50);

    logic          clk = 1'b0;
    logic          rst_n, region_50, rd_status, irq_en;
    logic [HW-1:0] h_count;
    logic [VW-1:0] v_count;
    logic          active, hsync, vsync, irq;
    logic [7:0]    status;

    always #2 clk = ~clk;

    vft_frame_timer #(
        .H_TOTAL(HT), .H_ACTIVE(HA), .H_SYNC_START(HSS), .H_SYNC_LEN(HSL),
        .V_ACTIVE(VA), .V_TOTAL_60(VT60), .V_TOTAL_50(VT50),
        .V_SYNC_START_60(VS60), .V_SYNC_START_50(VS50), .V_SYNC_LEN(VSL)
    ) dut (
        .clk(clk), .rst_n(rst_n), .region_50(region_50), .rd_status(rd_status),
        .irq_en(irq_en), .h_count(h_count), .v_count(v_count), .active(active),
        .hsync(hsync), .vsync(vsync), .status(status), .irq(irq)
    );

    int  errors = 0;
    int  checks = 0;
    int  cyc    = 0;
    bit  done   = 0;

    // Behavioural reference: beam position, sampled region, frame flag
    int  mh = 0, mv = 0, mreg = 0, mflag = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mh = 0; mv = 0; mreg = 0; mflag = 0;
        end else begin
            cyc = cyc + 1;
            if (rd_status) mflag = 0;
            if (mh == HT - 1 && mv == VA - 1) mflag = 1;
            mh = mh + 1;
            if (mh == HT) begin
                mh = 0;
                mv = mv + 1;
                if (mv == ((mreg != 0) ? VT50 : VT60)) begin
                    mv = 0;
                    mreg = region_50 ? 1 : 0;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the reference
    always @(negedge clk) begin
        if (!done) begin
            int vss;
            int e_act, e_hs, e_vs, e_st, e_irq;
            vss   = (mreg != 0) ? VS50 : VS60;
            e_act = (mh < HA && mv < VA) ? 1 : 0;
            e_hs  = (mh >= HSS && mh < HSS + HSL) ? 1 : 0;
            e_vs  = (mv >= vss && mv < vss + VSL) ? 1 : 0;
            e_st  = mflag * 128;
            e_irq = (mflag != 0 && irq_en) ? 1 : 0;
            chk(int'(h_count) == mh, "R1 h_count", int'(h_count), mh);
            chk(int'(v_count) == mv, "R1/R2/R3 v_count", int'(v_count), mv);
            chk(int'(active) == e_act, "R4 active", int'(active), e_act);
            chk(int'(hsync) == e_hs, "R5 hsync", int'(hsync), e_hs);
            chk(int'(vsync) == e_vs, "R5/R3 vsync", int'(vsync), e_vs);
            chk(int'(status) == e_st, "R6/R7/R8 status", int'(status), e_st);
            chk(int'(irq) == e_irq, "R9 irq", int'(irq), e_irq);
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic wait_flag(output int t);
        do @(negedge clk); while (!status[7]);
        t = cyc;
        chk(int'(v_count) == VA, "R6 flag rise line", int'(v_count), VA);
        chk(h_count == '0, "R6 flag rise pixel", int'(h_count), 0);
        chk(status[6:0] == 7'd0, "R6 low bits zero", int'(status[6:0]), 0);
    endtask

    task automatic read_status();
        @(posedge clk); #1 rd_status = 1'b1;
        @(negedge clk);
        chk(status == 8'h80, "R7 byte during read", int'(status), 128);
        @(posedge clk); #1 rd_status = 1'b0;
        @(negedge clk);
        chk(status[7] == 1'b0, "R7 cleared after read", int'(status[7]), 0);
        chk(irq == 1'b0, "R9 irq drops with flag", int'(irq), 0);
    endtask

    task automatic check_reset_state();
        chk(h_count == '0, "R10 h_count", int'(h_count), 0);
        chk(v_count == '0, "R10 v_count", int'(v_count), 0);
        chk(status == 8'h00, "R10 status", int'(status), 0);
        chk(!hsync && !vsync, "R10 syncs", int'({hsync, vsync}), 0);
    endtask

    initial begin
        #(150000 * 4);
        errors = errors + 1;
        checks = checks + 1;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        int t0, t1, t2, t3, t4;
        rst_n = 1'b0; region_50 = 1'b0; rd_status = 1'b0; irq_en = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check_reset_state();

        @(posedge clk); #1 irq_en = 1'b1;
        wait_flag(t0);
        chk(irq == 1'b1, "R9 irq follows flag", int'(irq), 1);
        read_status();

        wait_flag(t1);
        chk(t1 - t0 == VT60 * HT, "R2 60 Hz frame length", t1 - t0, VT60 * HT);
        @(posedge clk); #1 region_50 = 1'b1;
        read_status();

        wait_flag(t2);
        chk(t2 - t1 == VT60 * HT, "R3 region change mid-frame ignored", t2 - t1, VT60 * HT);
        read_status();

        wait_flag(t3);
        chk(t3 - t2 == VT50 * HT, "R2 50 Hz frame length", t3 - t2, VT50 * HT);
        @(posedge clk); #1 region_50 = 1'b0;
        read_status();

        wait_flag(t4);
        chk(t4 - t3 == VT50 * HT, "R3 return to 60 Hz waits for boundary", t4 - t3, VT50 * HT);
        read_status();

        // Read colliding with the frame event
        do begin @(posedge clk); #1; end
        while (!(int'(h_count) == HT - 1 && int'(v_count) == VA - 1));
        rd_status = 1'b1;
        @(posedge clk); #1 rd_status = 1'b0;
        @(negedge clk);
        chk(status[7] == 1'b1, "R8 set wins over read", int'(status[7]), 1);

        @(posedge clk); #1 irq_en = 1'b0;
        @(negedge clk);
        chk(irq == 1'b0, "R9 irq masked", int'(irq), 0);

        @(posedge clk); #1 rst_n = 1'b0;
        @(negedge clk);
        check_reset_state();
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (40) @(posedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule